// File: doc/BRIEF.md
# Status-Decoding Bus Command Controller

This block sits beside a processor running in its multi-master configuration. The processor does not drive separate read and write pins. It reports the kind of each bus cycle as a 3-bit encoded status. The controller watches that status on the processor clock. It follows each bus cycle through its four phases, T1 to T4, and drives the strobes the rest of the system needs:

- one active-low command line for each kind of access: memory read, memory write, I/O read, I/O write and interrupt acknowledge;
- early versions of the two write commands;
- an address-latch strobe;
- a data-transceiver enable;
- a transceiver direction line.

A cycle starts when the status leaves the idle code 111 and ends one clock after the status returns to 111. The early write strobes open at T2, one clock ahead of the normal writes, so that slow devices gain a full clock of access time.

Two enable inputs qualify the command strobes: a command enable and an active-low address enable. A third input selects I/O-bus mode. In that mode the I/O-side commands no longer depend on either enable, and the memory commands depend only on the command enable. The address strobe, the data enable and the direction line are never gated.

Top module: `bus_cmd_ctrl`

## Requirements
- R1: A cycle starts at the first clock edge at which `bus_stat` is not 111 and the previous sampled value was 111, provided the controller is idle or in T4. `addr_strobe` is high for exactly the one clock that follows (T1) and is low at all other times.
- R2: Status codes map to commands as follows: 000 to `int_ack_n`, 001 to `io_rd_n`, 010 to `io_wr_n`/`io_wr_early_n`, 100 and 101 to `mem_rd_n`, 110 to `mem_wr_n`/`mem_wr_early_n`. The codes 011 (halt) and 111 (idle) assert no command.
- R3: Read-type commands (`mem_rd_n`, `io_rd_n`, `int_ack_n`) are low during T2 and during every T3 clock, including wait clocks. They are high in T1, in T4 and while idle.
- R4: Early write strobes are low during T2 and T3. Normal write strobes are low during T3 only. A normal write is therefore never low without its early strobe.
- R5: The controller stays in T3 for as long as the sampled status is not 111. The first edge that samples 111 in T3 moves it to T4. T4 lasts one clock, after which the controller goes idle or starts a new cycle directly.
- R6: At most one of `mem_rd_n`, `mem_wr_n`, `io_rd_n`, `io_wr_n`, `int_ack_n` is low at any time.
- R7: `data_en` is high during T2 and T3 of every cycle except halt, and low otherwise.
- R8: `data_dir_tx` is low from T1 through T4 of cycles with status 000, 001, 100 or 101. It is high at every other time, including idle and write and halt cycles.
- R9: With `io_bus_sel` = 0, every command strobe stays high unless `cmd_gate` = 1 and `addr_gate_n` = 0.
- R10: With `io_bus_sel` = 1, `io_rd_n`, `io_wr_n`, `io_wr_early_n` and `int_ack_n` ignore both enables. The memory commands require only `cmd_gate` = 1.
- R11: Reset (active-low `rst_n`) leaves every command high, `addr_strobe` and `data_en` low and `data_dir_tx` high. Two back-to-back acknowledge cycles each give one separate `int_ack_n` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_stat | input | 3 | Encoded bus cycle status from the processor |
| cmd_gate | input | 1 | Command enable, active high |
| addr_gate_n | input | 1 | Address enable, active low |
| io_bus_sel | input | 1 | Selects I/O-bus mode |
| mem_rd_n | output | 1 | Memory read command |
| mem_wr_n | output | 1 | Memory write command |
| mem_wr_early_n | output | 1 | Early memory write command |
| io_rd_n | output | 1 | I/O read command |
| io_wr_n | output | 1 | I/O write command |
| io_wr_early_n | output | 1 | Early I/O write command |
| int_ack_n | output | 1 | Interrupt acknowledge |
| addr_strobe | output | 1 | Address latch strobe, high in T1 |
| data_en | output | 1 | Data transceiver enable |
| data_dir_tx | output | 1 | Transceiver direction, 1 = outbound |

## Verification
The assertions assume the processor follows the bus protocol: the status holds one non-idle code from the start of a cycle until it returns to 111 in T3, and it never goes idle during T1 or T2. The stimulus keeps to this rule. It changes the status only on falling edges, at cycle starts and when the cycle leaves T3. It draws the cycle kind, the number of wait clocks, the enable levels and the mode from a seeded generator. Directed cycles cover every code, both modes with the enables closed, long waits and back-to-back acknowledges.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

  localparam int STAT_W = 3;
  localparam int NCMD   = 7;

  // command slot indices
  localparam int CI_MRD   = 0;
  localparam int CI_MWR   = 1;
  localparam int CI_AMWR  = 2;
  localparam int CI_IORD  = 3;
  localparam int CI_IOWR  = 4;
  localparam int CI_AIOWR = 5;
  localparam int CI_INTA  = 6;

  typedef enum logic [STAT_W-1:0] {
    ST_INTA  = 3'b000,
    ST_IORD  = 3'b001,
    ST_IOWR  = 3'b010,
    ST_HALT  = 3'b011,
    ST_FETCH = 3'b100,
    ST_MRD   = 3'b101,
    ST_MWR   = 3'b110,
    ST_PASS  = 3'b111
  } bus_stat_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_T4   = 3'd4
  } bus_phase_e;

  // commands that belong to the I/O side (gated differently in I/O-bus mode)
  function automatic bit is_io_cmd(int unsigned idx);
    return (idx == CI_IORD) || (idx == CI_IOWR) ||
           (idx == CI_AIOWR) || (idx == CI_INTA);
  endfunction

  // cycle kinds whose data flows toward the processor
  function automatic logic kind_reads(bus_stat_e k);
    return (k == ST_INTA) || (k == ST_IORD) || (k == ST_FETCH) || (k == ST_MRD);
  endfunction

  // cycle kinds that transfer data at all
  function automatic logic kind_moves_data(bus_stat_e k);
    return (k != ST_HALT) && (k != ST_PASS);
  endfunction

  // ungated command set for a cycle kind in a given phase
  function automatic logic [NCMD-1:0] raw_cmds(bus_stat_e k, bus_phase_e p);
    logic [NCMD-1:0] r;
    logic win;
    logic late;
    win  = (p == PH_T2) || (p == PH_T3);
    late = (p == PH_T3);
    r    = '0;
    case (k)
      ST_INTA:         r[CI_INTA] = win;
      ST_IORD:         r[CI_IORD] = win;
      ST_IOWR: begin
        r[CI_IOWR]  = late;
        r[CI_AIOWR] = win;
      end
      ST_FETCH, ST_MRD: r[CI_MRD] = win;
      ST_MWR: begin
        r[CI_MWR]  = late;
        r[CI_AMWR] = win;
      end
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bcc_phase_seq.sv
module bcc_phase_seq
  import bcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  bus_stat_e  stat,
  output bus_phase_e phase,
  output bus_stat_e  kind,
  output logic       cyc_start
);

  bus_stat_e stat_q;

  assign cyc_start = ((phase == PH_IDLE) || (phase == PH_T4)) &&
                     (stat != ST_PASS) && (stat_q == ST_PASS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      kind   <= ST_PASS;
      stat_q <= ST_PASS;
    end else begin
      stat_q <= stat;
      case (phase)
        PH_IDLE: begin
          if (cyc_start) begin
            phase <= PH_T1;
            kind  <= stat;
          end
        end
        PH_T1: phase <= PH_T2;
        PH_T2: phase <= PH_T3;
        PH_T3: if (stat == ST_PASS) phase <= PH_T4;
        PH_T4: begin
          if (cyc_start) begin
            phase <= PH_T1;
            kind  <= stat;
          end else begin
            phase <= PH_IDLE;
            kind  <= ST_PASS;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_T3 && stat != ST_PASS) |=> (phase == PH_T3)); // R5

  AST_T4_AFTER_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_T4) |-> ($past(stat) == ST_PASS)); // R5

  AST_KIND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_T2 || phase == PH_T3) |-> $stable(kind)); // R2

endmodule

// File: rtl/bcc_decode.sv
module bcc_decode
  import bcc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  bus_phase_e       phase,
  input  bus_stat_e        kind,
  output logic [NCMD-1:0]  raw,
  output logic             ale,
  output logic             den,
  output logic             dir_tx
);

  always_comb begin
    raw    = raw_cmds(kind, phase);
    ale    = (phase == PH_T1);
    den    = ((phase == PH_T2) || (phase == PH_T3)) && kind_moves_data(kind);
    dir_tx = !((phase != PH_IDLE) && kind_reads(kind));
  end

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ST_HALT) |-> (raw == '0 && !den)); // R2

  AST_ALE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale); // R1

endmodule

// File: rtl/bcc_gate.sv
module bcc_gate
  import bcc_pkg::*;
#(
  parameter int N = NCMD
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  input  logic         ale,
  input  logic         cmd_gate,
  input  logic         addr_gate_n,
  input  logic         io_bus_sel,
  output logic [N-1:0] cmd_n
);

  logic mem_ok;
  logic io_ok;

  assign mem_ok = cmd_gate && (io_bus_sel || !addr_gate_n);
  assign io_ok  = io_bus_sel || (cmd_gate && !addr_gate_n);

  for (genvar g = 0; g < N; g++) begin : g_cmd
    localparam bit IS_IO = is_io_cmd(g);
    if (IS_IO) begin : g_io
      assign cmd_n[g] = ~(raw[g] & io_ok);
    end else begin : g_mem
      assign cmd_n[g] = ~(raw[g] & mem_ok);
    end
  end

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~{cmd_n[CI_MRD], cmd_n[CI_MWR], cmd_n[CI_IORD],
                 cmd_n[CI_IOWR], cmd_n[CI_INTA]}) <= 1); // R6

  AST_MEM_EARLY_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_n[CI_MWR] |-> !cmd_n[CI_AMWR]); // R4

  AST_IO_EARLY_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_n[CI_IOWR] |-> !cmd_n[CI_AIOWR]); // R4

  AST_NO_CMD_IN_T1: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (&cmd_n)); // R3

endmodule

// File: rtl/bus_cmd_ctrl.sv
module bus_cmd_ctrl
  import bcc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [STAT_W-1:0] bus_stat,
  input  logic             cmd_gate,
  input  logic             addr_gate_n,
  input  logic             io_bus_sel,
  output logic             mem_rd_n,
  output logic             mem_wr_n,
  output logic             mem_wr_early_n,
  output logic             io_rd_n,
  output logic             io_wr_n,
  output logic             io_wr_early_n,
  output logic             int_ack_n,
  output logic             addr_strobe,
  output logic             data_en,
  output logic             data_dir_tx
);

  bus_stat_e       stat_e;
  bus_phase_e      phase;
  bus_stat_e       kind;
  logic            cyc_start;
  logic [NCMD-1:0] raw;
  logic [NCMD-1:0] cmd_n;
  logic            ale;
  logic            den;
  logic            dir_tx;

  assign stat_e = bus_stat_e'(bus_stat);

  bcc_phase_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .stat      (stat_e),
    .phase     (phase),
    .kind      (kind),
    .cyc_start (cyc_start)
  );

  bcc_decode u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .phase  (phase),
    .kind   (kind),
    .raw    (raw),
    .ale    (ale),
    .den    (den),
    .dir_tx (dir_tx)
  );

  bcc_gate #(.N(NCMD)) u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .raw         (raw),
    .ale         (ale),
    .cmd_gate    (cmd_gate),
    .addr_gate_n (addr_gate_n),
    .io_bus_sel  (io_bus_sel),
    .cmd_n       (cmd_n)
  );

  assign mem_rd_n       = cmd_n[CI_MRD];
  assign mem_wr_n       = cmd_n[CI_MWR];
  assign mem_wr_early_n = cmd_n[CI_AMWR];
  assign io_rd_n        = cmd_n[CI_IORD];
  assign io_wr_n        = cmd_n[CI_IOWR];
  assign io_wr_early_n  = cmd_n[CI_AIOWR];
  assign int_ack_n      = cmd_n[CI_INTA];
  assign addr_strobe    = ale;
  assign data_en        = den;
  assign data_dir_tx    = dir_tx;

  AST_START_GIVES_T1: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> addr_strobe); // R1

  AST_READ_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd_n || !io_rd_n || !int_ack_n) |-> !data_dir_tx); // R8

endmodule

// File: tb/bus_cmd_ctrl_tb.sv
module bus_cmd_ctrl_tb;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_stat = 3'b111;
  logic       cmd_gate = 1'b1;
  logic       addr_gate_n = 1'b0;
  logic       io_bus_sel = 1'b0;
  logic mem_rd_n, mem_wr_n, mem_wr_early_n, io_rd_n, io_wr_n, io_wr_early_n;
  logic int_ack_n, addr_strobe, data_en, data_dir_tx;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_cmd_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_stat(bus_stat), .cmd_gate(cmd_gate),
    .addr_gate_n(addr_gate_n), .io_bus_sel(io_bus_sel),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .mem_wr_early_n(mem_wr_early_n),
    .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .io_wr_early_n(io_wr_early_n),
    .int_ack_n(int_ack_n), .addr_strobe(addr_strobe), .data_en(data_en),
    .data_dir_tx(data_dir_tx)
  );

  // active-high command view: {inta, io_wr_early, io_wr, io_rd, mem_wr_early, mem_wr, mem_rd}
  function automatic logic [6:0] seen_cmds();
    return ~{int_ack_n, io_wr_early_n, io_wr_n, io_rd_n,
             mem_wr_early_n, mem_wr_n, mem_rd_n};
  endfunction

  function automatic logic [6:0] want_cmds(int k, int ph, bit cg, bit ag_n, bit iob);
    logic [6:0] e;
    bit win, late, m_ok, i_ok;
    win  = (ph == 2) || (ph == 3);
    late = (ph == 3);
    m_ok = cg && (iob || !ag_n);
    i_ok = iob || (cg && !ag_n);
    e = '0;
    if (k == 0) e[6] = win && i_ok;
    if (k == 1) e[3] = win && i_ok;
    if (k == 2) begin e[4] = late && i_ok; e[5] = win && i_ok; end
    if (k == 4 || k == 5) e[0] = win && m_ok;
    if (k == 6) begin e[1] = late && m_ok; e[2] = win && m_ok; end
    return e;
  endfunction

  function automatic bit want_den(int k, int ph);
    return ((ph == 2) || (ph == 3)) && (k != 3) && (k != 7);
  endfunction

  function automatic bit want_dir(int k, int ph);
    return !((ph != 0) && (k == 0 || k == 1 || k == 4 || k == 5));
  endfunction

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic sample(int k, int ph, bit cg, bit ag_n, bit iob, string tag, bit waiting);
    string ctag;
    logic [6:0] c;
    c = seen_cmds();
    if (tag != "") ctag = tag;
    else if (iob) ctag = "R10";
    else if (!cg || ag_n) ctag = "R9";
    else if (waiting || ph == 4) ctag = "R5";
    else if (k == 2 || k == 6) ctag = "R4";
    else ctag = "R3";
    chk("R1", "addr_strobe", {7'd0, addr_strobe}, {7'd0, ph == 1});
    chk(ctag, "commands", {1'b0, c}, {1'b0, want_cmds(k, ph, cg, ag_n, iob)});
    chk("R6", "one command", {7'd0, $countones(c & 7'b1011011) <= 1}, 8'd1);
    chk("R7", "data_en", {7'd0, data_en}, {7'd0, want_den(k, ph)});
    chk("R8", "data_dir_tx", {7'd0, data_dir_tx}, {7'd0, want_dir(k, ph)});
  endtask

  // entered and left at a falling edge
  task automatic run_cycle(int k, int waits, bit cg, bit ag_n, bit iob, string tag);
    cmd_gate = cg; addr_gate_n = ag_n; io_bus_sel = iob;
    bus_stat = 3'(k);
    @(posedge clk); @(negedge clk); sample(k, 1, cg, ag_n, iob, tag, 0);
    @(posedge clk); @(negedge clk); sample(k, 2, cg, ag_n, iob, tag, 0);
    @(posedge clk); @(negedge clk); sample(k, 3, cg, ag_n, iob, tag, 0);
    for (int w = 0; w < waits; w++) begin
      @(posedge clk); @(negedge clk); sample(k, 3, cg, ag_n, iob, tag, 1);
    end
    bus_stat = 3'b111;
    @(posedge clk); @(negedge clk); sample(k, 4, cg, ag_n, iob, tag, 0);
  endtask

  task automatic idle_gap(int n, string tag);
    bus_stat = 3'b111;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      sample(7, 0, cmd_gate, addr_gate_n, io_bus_sel, tag, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(posedge clk);
    @(negedge clk);
    sample(7, 0, 1, 0, 0, "R11", 0);   // R11 reset state
    rst_n = 1'b1;
    idle_gap(2, "R2");

    // R2: every code with gates open, idle code gives nothing
    for (int k = 0; k < 7; k++) begin
      run_cycle(k, 1, 1, 0, 0, "R2");
      idle_gap(1, "R2");
    end
    // R5: long wait, back-to-back cycles
    run_cycle(5, 5, 1, 0, 0, "R5");
    run_cycle(6, 4, 1, 0, 0, "R5");
    // R9: closed enables in normal mode
    run_cycle(5, 0, 0, 0, 0, "R9");
    run_cycle(1, 0, 1, 1, 0, "R9");
    run_cycle(6, 1, 1, 1, 0, "R9");
    // R10: I/O-bus mode
    run_cycle(2, 1, 0, 1, 1, "R10");
    run_cycle(0, 0, 0, 1, 1, "R10");
    run_cycle(6, 0, 1, 1, 1, "R10");
    run_cycle(5, 0, 0, 0, 1, "R10");
    idle_gap(1, "R10");
    // R11: two acknowledge cycles back to back
    run_cycle(0, 0, 1, 0, 0, "R11");
    run_cycle(0, 1, 1, 0, 0, "R11");
    idle_gap(2, "R11");

    // random traffic
    for (int n = 0; n < 400; n++) begin
      int k;
      k = int'($urandom_range(0, 6));
      run_cycle(k, int'($urandom_range(0, 3)),
                $urandom_range(0, 9) < 8, $urandom_range(0, 9) < 2,
                $urandom_range(0, 3) == 0, "");
      idle_gap(int'($urandom_range(0, 2)), "");
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule